// File: doc/BRIEF.md
# Indirect Oscillator Configuration Engine

This block gives software indirect access to a small bank of 32-bit oscillator frequency words. Those words are not mapped onto the register bus one by one. Software works through a group of four registers:

- a data-to-send register;
- a returned-data register;
- a command register that selects a function code, a device index and a direction;
- a status register that reports completion and error.

A command written with its start bit set runs in the same clock edge that stores the command. A write copies the data-to-send register into the selected oscillator word. A read copies the selected word into the returned-data register. The status then shows done, and it also shows error when the target does not exist.

The current oscillator words are driven on an output port, so the clock generators that sit outside the block can use them. Each word reloads its own parameter value on reset. Bus reads return data one clock after the read strobe.

Top module: `cfg_xact_engine`

## Requirements
- R1: After reset the command register reads 0x00100000 (function code 1). The data-to-send, returned-data and status registers read 0. Oscillator word i on `osc_out[32*i +: 32]` equals slice i of the `OSC_INIT` parameter.
- R2: The command register keeps only these fields when stored: device index in bits [11:0], function code in bits [25:20], and the direction in bit 30 (1 = write to the oscillator word, 0 = read it). Bits [19:12], bits [29:26] and the start bit 31 always read back as 0.
- R3: Every bus write to the command register clears the status register. When start (bit 31) is clear, the status stays 0 and no oscillator word changes.
- R4: A command with start set, function code 1, device index below `N_OSC` and direction 1 copies the data-to-send register into that oscillator word. The status then reads 1 (bit 0 = done, bit 1 = error).
- R5: A command with start set, function code 1, device index below `N_OSC` and direction 0 copies that oscillator word into the returned-data register. The status then reads 1.
- R6: A started command whose function code is not 1, or whose device index is `N_OSC` or more, leaves the status at 3 (done and error). No oscillator word changes, and the returned-data register keeps its old value.
- R7: The register byte offsets are 0xA0 (returned data, read-only), 0xA4 (data to send, read/write), 0xA8 (command) and 0xAC (status, read-only). Bus writes to 0xA0 and 0xAC have no effect. A read of any other offset returns 0.
- R8: `bus_rdata` holds the addressed value from the clock edge that samples `bus_rd`. A read issued in the cycle right after a command write already sees that command's status and results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| osc_out | output | 32*N_OSC | Oscillator words, entry i in bits [32*i +: 32] |

## Verification
The main stimulus sweeps the device index from 0 to `N_OSC`+2, the function code over 0, 1, 2 and 63, and both directions. Every command word also carries ones in the reserved bits. Function code 1 with an in-range index must update exactly one oscillator word or the returned-data register. A wrong function code and an index just past the top must be told apart from valid ones by the error bit, and by the unchanged oscillator and returned data. A data pattern that depends on device, function and direction shows which entry was written. Plain command writes after an error, writes to the read-only offsets, and a read of an unmapped offset check that status clears, that nothing is disturbed, and that unmapped reads return zero.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int WORD_W = 32;

  localparam logic [11:0] OFS_RTN  = 12'h0A0;
  localparam logic [11:0] OFS_SEND = 12'h0A4;
  localparam logic [11:0] OFS_CMD  = 12'h0A8;
  localparam logic [11:0] OFS_STAT = 12'h0AC;

  typedef struct packed {
    logic        start;
    logic        dir_wr;
    logic [3:0]  pad_hi;
    logic [5:0]  func;
    logic [7:0]  pad_lo;
    logic [11:0] dev;
  } cmd_word_t;

  localparam logic [WORD_W-1:0] CMD_KEEP  = 32'h43F0_0FFF;
  localparam logic [WORD_W-1:0] CMD_RESET = 32'h0010_0000;
  localparam logic [5:0]        FUNC_OSC  = 6'd1;
endpackage

// File: rtl/cfgx_osc_bank.sv
module cfgx_osc_bank #(
  parameter int N_OSC = 3,
  parameter int IDX_W = 2,
  parameter logic [N_OSC*32-1:0] OSC_INIT = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IDX_W-1:0]   idx,
  input  logic [31:0]        wdata,
  output logic [31:0]        rd_data,
  output logic [N_OSC*32-1:0] osc_flat
);
  logic [31:0] osc_q [N_OSC];

  for (genvar g = 0; g < N_OSC; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)
        osc_q[g] <= OSC_INIT[g*32 +: 32];
      else if (we && idx == IDX_W'(g))
        osc_q[g] <= wdata;
    end
    assign osc_flat[g*32 +: 32] = osc_q[g];

    // R3 / R6: an entry only moves after a write strobe that selects it
    p_entry_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !$past(we && idx == IDX_W'(g)) |-> $stable(osc_q[g]));
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_OSC; i++)
      if (idx == IDX_W'(i)) rd_data = osc_q[i];
  end
endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
  import cfgx_pkg::*;
#(
  parameter int N_OSC = 3,
  parameter int IDX_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic              send_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] osc_rd_data,
  output logic [WORD_W-1:0] cmd_q,
  output logic [1:0]        stat_q,
  output logic [WORD_W-1:0] send_q,
  output logic [WORD_W-1:0] rtn_q,
  output logic              osc_we,
  output logic [IDX_W-1:0]  osc_idx
);
  cmd_word_t w;
  logic      dev_ok, hit, go;

  always_comb begin
    w       = cmd_word_t'(wdata);
    dev_ok  = {20'b0, w.dev} < 32'(N_OSC);
    hit     = (w.func == FUNC_OSC) && dev_ok;
    go      = cmd_we && w.start;
    osc_we  = go && w.dir_wr && hit;
    osc_idx = w.dev[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= CMD_RESET;
      stat_q <= 2'b00;
      send_q <= '0;
      rtn_q  <= '0;
    end else begin
      if (send_we) send_q <= wdata;
      if (cmd_we) begin
        cmd_q  <= wdata & CMD_KEEP;
        stat_q <= go ? {~hit, 1'b1} : 2'b00;
        if (go && !w.dir_wr && hit) rtn_q <= osc_rd_data;
      end
    end
  end

  p_done_after_start_r4: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_we && wdata[31]) |-> stat_q[0]);

  p_error_implies_done_r6: assert property (@(posedge clk) disable iff (rst)
    stat_q[1] |-> stat_q[0]);

  p_plain_write_clears_r3: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_we && !wdata[31]) |-> stat_q == 2'b00);

  p_rtn_only_on_read_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(cmd_we && wdata[31] && !wdata[30]) |-> $stable(rtn_q));
endmodule

// File: rtl/cfg_xact_engine.sv
module cfg_xact_engine
  import cfgx_pkg::*;
#(
  parameter int N_OSC  = 3,
  parameter int ADDR_W = 12,
  parameter logic [N_OSC*32-1:0] OSC_INIT = {32'h00B7_1B00, 32'h02FA_F080, 32'h017D_7840}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [N_OSC*32-1:0] osc_out
);
  localparam int IDX_W = (N_OSC > 1) ? $clog2(N_OSC) : 1;

  logic [31:0]      cmd_q, send_q, rtn_q, osc_rd_data;
  logic [1:0]       stat_q;
  logic             osc_we, cmd_we, send_we, mapped;
  logic [IDX_W-1:0] osc_idx;

  always_comb begin
    cmd_we  = bus_wr && (bus_addr == ADDR_W'(OFS_CMD));
    send_we = bus_wr && (bus_addr == ADDR_W'(OFS_SEND));
    mapped  = (bus_addr == ADDR_W'(OFS_RTN))  || (bus_addr == ADDR_W'(OFS_SEND)) ||
              (bus_addr == ADDR_W'(OFS_CMD))  || (bus_addr == ADDR_W'(OFS_STAT));
  end

  cfgx_ctrl #(.N_OSC(N_OSC), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .send_we(send_we),
    .wdata(bus_wdata), .osc_rd_data(osc_rd_data),
    .cmd_q(cmd_q), .stat_q(stat_q), .send_q(send_q), .rtn_q(rtn_q),
    .osc_we(osc_we), .osc_idx(osc_idx)
  );

  cfgx_osc_bank #(.N_OSC(N_OSC), .IDX_W(IDX_W), .OSC_INIT(OSC_INIT)) u_bank (
    .clk(clk), .rst(rst), .we(osc_we), .idx(osc_idx), .wdata(send_q),
    .rd_data(osc_rd_data), .osc_flat(osc_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_addr == ADDR_W'(OFS_RTN))       bus_rdata <= rtn_q;
      else if (bus_addr == ADDR_W'(OFS_SEND)) bus_rdata <= send_q;
      else if (bus_addr == ADDR_W'(OFS_CMD))  bus_rdata <= cmd_q;
      else if (bus_addr == ADDR_W'(OFS_STAT)) bus_rdata <= {30'b0, stat_q};
      else                                    bus_rdata <= '0;
    end
  end

  p_unmapped_reads_zero_r7: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && !mapped) |-> bus_rdata == 32'h0);

  p_rdata_holds_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata));
endmodule

// File: tb/cfg_xact_engine_test.sv
`timescale 1ns/1ps
module cfg_xact_engine_test;
  localparam int N = 3;
  localparam logic [N*32-1:0] INIT = {32'h00B7_1B00, 32'h02FA_F080, 32'h017D_7840};

  logic clk = 0, rst = 1, bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [N*32-1:0] osc_out;
  int checks = 0, fails = 0;
  bit finished = 0;

  logic [31:0] exp_osc [N];
  logic [31:0] exp_rtn;

  always #2 clk = ~clk;

  cfg_xact_engine #(.N_OSC(N), .ADDR_W(12), .OSC_INIT(INIT)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_out(osc_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic chk_osc(input string req);
    for (int i = 0; i < N; i++) chk(req, osc_out[i*32 +: 32], exp_osc[i]);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int i = 0; i < N; i++) exp_osc[i] = INIT[i*32 +: 32];
    exp_rtn = 0;
    // R1 reset state
    rd(12'h0A8, v); chk("R1 cmd reset", v, 32'h0010_0000);
    rd(12'h0A4, v); chk("R1 send reset", v, 0);
    rd(12'h0A0, v); chk("R1 rtn reset", v, 0);
    rd(12'h0AC, v); chk("R1 stat reset", v, 0);
    chk_osc("R1 osc reset");
    // R4/R5/R6/R2 sweep over device, function, direction
    for (int dev = 0; dev < N + 3; dev++) begin
      for (int fi = 0; fi < 4; fi++) begin
        for (int dir = 0; dir < 2; dir++) begin
          logic [5:0] fn;
          logic [31:0] data, cw;
          bit ok;
          fn = (fi == 0) ? 6'd0 : (fi == 1) ? 6'd1 : (fi == 2) ? 6'd2 : 6'd63;
          data = 32'hA500_0000 ^ (dev << 12) ^ (32'(fn) << 4) ^ (dir << 20) ^ 32'h5A;
          ok = (fn == 6'd1) && (dev < N);
          wr(12'h0A4, data);
          cw = 32'h8000_0000 | (32'(dir) << 30) | 32'h3C0F_F000 | (32'(fn) << 20) | 32'(dev);
          wr(12'h0A8, cw);
          if (ok && dir == 1) exp_osc[dev] = data;
          if (ok && dir == 0) exp_rtn = exp_osc[dev];
          rd(12'h0AC, v);
          if (ok) chk(dir ? "R4 stat done" : "R5 stat done", v, 32'h1);
          else    chk("R6 stat error", v, 32'h3);
          rd(12'h0A8, v); chk("R2 cmd masked", v, cw & 32'h43F0_0FFF);
          rd(12'h0A0, v); chk(ok ? "R5 rtn value" : "R6 rtn kept", v, exp_rtn);
          chk_osc(ok ? "R4 osc value" : "R6 osc unchanged");
        end
      end
    end
    // R8: read in the cycle right after a command write
    @(negedge clk); bus_addr = 12'h0A8; bus_wdata = 32'hC010_0001; bus_wr = 1;
    @(negedge clk); bus_wr = 0; bus_addr = 12'h0AC; bus_rd = 1;
    exp_osc[1] = 32'hA500_0000 ^ (5 << 12) ^ (63 << 4) ^ (1 << 20) ^ 32'h5A;
    @(negedge clk); bus_rd = 0; chk("R8 stat next cycle", bus_rdata, 32'h1);
    chk_osc("R8 osc next cycle");
    // R3: error, then plain command write clears status without effect
    wr(12'h0A8, 32'h8020_0000);
    rd(12'h0AC, v); chk("R6 bad func", v, 32'h3);
    wr(12'h0A4, 32'hDEAD_BEEF);
    wr(12'h0A8, 32'h4010_0000);
    rd(12'h0AC, v); chk("R3 stat cleared", v, 0);
    chk_osc("R3 osc untouched");
    rd(12'h0A0, v); chk("R3 rtn untouched", v, exp_rtn);
    // R7: read-only and unmapped offsets
    wr(12'h0A0, 32'h1234_5678);
    rd(12'h0A0, v); chk("R7 rtn read-only", v, exp_rtn);
    wr(12'h0A8, 32'h8010_0000);
    wr(12'h0AC, 32'h0000_0000);
    rd(12'h0AC, v); chk("R7 stat read-only", v, 32'h1);
    rd(12'h0A0, v); chk("R5 rtn dev0", v, exp_osc[0]);
    rd(12'h0B0, v); chk("R7 unmapped", v, 0);
    rd(12'h000, v); chk("R7 unmapped low", v, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule